// File: doc/BRIEF.md
# Three-Wire Serial Register Master

This block is the host side of a three-wire serial link to a bridge device's register port. It drives an active-low chip select, a serial clock and a data-out line. It can also listen on a return data line. A requester asks for a register write or a register read over a valid/ready command port. The block then runs the whole exchange on the wire by itself.

Every access takes two 24-bit frames, separated by a short period with chip select high:

- The first frame names the register.
- The second frame carries the write value, or the read opcode.

During a read, the block collects the bits the device returns in the second frame. It reports the last 16 of them with a one-cycle completion pulse. The half-bit time and the chip-select guard time are build parameters counted in system clock cycles. A builder with no return line can set a parameter that removes the capture logic, which makes the block write-only.

Top module: `spi3w_reg_master`

## Requirements
- R1: After reset and whenever no access is running, `cmd_ready` is 1, `done` is 0, and `spi_cs_n`, `spi_sck` and `spi_mosi` are all 1.
- R2: Each frame has exactly 24 clock rising edges, and the bits go out most significant bit first. The first frame of every access is {8'h70, 8'h00, index}, with the register index in bits 7:0.
- R3: For a write, the second frame is {8'h72, value}, with the 16-bit value in bits 15:0.
- R4: For a read, the second frame is 24'h730000. `rdata` holds the last 16 bits sampled on `spi_miso` during that frame, with the earliest of those 16 bits in bit 15.
- R5: `spi_mosi` changes only while `spi_sck` is low. Each low phase and each high phase inside a frame lasts HALF_CYC cycles. `spi_miso` is sampled at the end of the low phase.
- R6: `spi_cs_n` falls GUARD_CYC cycles before the first clock falling edge. It rises GUARD_CYC cycles after the final high phase ends, which is HALF_CYC+GUARD_CYC cycles after the last rising edge. `spi_sck` is high whenever chip select changes.
- R7: Between the two frames of an access, `spi_cs_n` stays high for exactly GUARD_CYC cycles.
- R8: A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both 1. While an access is running, `cmd_ready` is 0 and `cmd_valid` has no effect. `done` is a one-cycle pulse that appears in the cycle `cmd_ready` returns to 1.
- R9: For a write, `rdata` is 0 when `done` pulses.
- R10: When HAS_MISO is 0, reads still send both frames, but `rdata` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| cmd_rd | input | 1 | 1 = register read, 0 = register write |
| cmd_idx | input | 8 | Register index |
| cmd_wdata | input | 16 | Write value |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with `done` |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, rests high |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench runs writes and reads with these patterns:

- all-zero and all-one indices and values, which show whether any bit is stuck or dropped;
- alternating patterns, which expose bit-order and shift-direction errors;
- device replies whose upper byte differs from their lower 16 bits, which check that only the last 16 sampled bits are kept.

A bus monitor measures every clock phase, lead guard, tail guard and inter-frame gap against the parameters. A second write-only instance receives the same commands, to check that its read result stays zero. Separate directed cases hold `cmd_valid` high during a busy access, and check that `done` and `cmd_ready` line up.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
   localparam int FRAME_W = 24;
   localparam int IDX_W   = 8;
   localparam int VAL_W   = 16;
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam logic [7:0] PFX_INDEX = 8'h70;
   localparam logic [7:0] PFX_WRITE = 8'h72;
   localparam logic [7:0] PFX_READ  = 8'h73;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_TAIL, ST_GAP
   } seq_state_t;
endpackage

// File: rtl/spi3w_timer.sv
module spi3w_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi3w_seq.sv
module spi3w_seq
   import spi3w_pkg::*;
#(
   parameter int HALF_CYC  = 4,
   parameter int GUARD_CYC = 8,
   parameter int CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output seq_state_t       state,
   output logic             accept,
   output logic             drive_first,
   output logic             shift,
   output logic             sample,
   output logic             park,
   output logic             load_second,
   output logic             finish,
   output logic             done
);
   localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] GUARD_LD = CNT_W'(GUARD_CYC - 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

   seq_state_t       st_q, st_d;
   logic [BIT_W-1:0] bit_q;
   logic             second_q;
   logic             done_q;

   always_comb begin
      st_d        = st_q;
      tmr_load    = 1'b0;
      tmr_val     = '0;
      accept      = 1'b0;
      drive_first = 1'b0;
      shift       = 1'b0;
      sample      = 1'b0;
      park        = 1'b0;
      load_second = 1'b0;
      finish      = 1'b0;
      case (st_q)
         ST_IDLE: if (cmd_valid) begin
            accept = 1'b1; st_d = ST_LEAD; tmr_load = 1'b1; tmr_val = GUARD_LD;
         end
         ST_LEAD: if (tmr_expired) begin
            drive_first = 1'b1; st_d = ST_LOW; tmr_load = 1'b1; tmr_val = HALF_LD;
         end
         ST_LOW: if (tmr_expired) begin
            sample = 1'b1; st_d = ST_HIGH; tmr_load = 1'b1; tmr_val = HALF_LD;
         end
         ST_HIGH: if (tmr_expired) begin
            tmr_load = 1'b1;
            if (bit_q == LAST_BIT) begin
               st_d = ST_TAIL; tmr_val = GUARD_LD;
            end else begin
               shift = 1'b1; st_d = ST_LOW; tmr_val = HALF_LD;
            end
         end
         ST_TAIL: if (tmr_expired) begin
            park = 1'b1; st_d = ST_GAP; tmr_load = 1'b1; tmr_val = GUARD_LD;
         end
         ST_GAP: if (tmr_expired) begin
            if (second_q) begin
               finish = 1'b1; st_d = ST_IDLE;
            end else begin
               load_second = 1'b1; st_d = ST_LEAD;
               tmr_load = 1'b1; tmr_val = GUARD_LD;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         bit_q    <= '0;
         second_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= finish;
         if (drive_first)      bit_q <= '0;
         else if (shift)       bit_q <= bit_q + 1'b1;
         if (accept)           second_q <= 1'b0;
         else if (load_second) second_q <= 1'b1;
      end
   end

   assign state = st_q;
   assign done  = done_q;
endmodule

// File: rtl/spi3w_txshift.sv
module spi3w_txshift
   import spi3w_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_first,
   input  logic [FRAME_W-1:0] first_word,
   input  logic [FRAME_W-1:0] second_word,
   input  logic               load_second,
   input  logic               drive_first,
   input  logic               shift,
   input  logic               park,
   output logic               mosi
);
   logic [FRAME_W-1:0] sh_q, hold_q;
   logic               mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         hold_q <= '0;
         mosi_q <= 1'b1;
      end else begin
         if (load_first) begin
            sh_q   <= first_word;
            hold_q <= second_word;
         end else if (load_second) begin
            sh_q <= hold_q;
         end else if (shift) begin
            sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
         end
         if (drive_first)  mosi_q <= sh_q[FRAME_W-1];
         else if (shift)   mosi_q <= sh_q[FRAME_W-2];
         else if (park)    mosi_q <= 1'b1;
      end
   end

   assign mosi = mosi_q;
endmodule

// File: rtl/spi3w_rxshift.sv
module spi3w_rxshift
   import spi3w_pkg::*;
#(
   parameter bit HAS_MISO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             cmd_rd,
   input  logic             sample,
   input  logic             miso,
   input  logic             finish,
   output logic [VAL_W-1:0] rdata
);
   generate
      if (HAS_MISO) begin : g_rx
         logic [VAL_W-1:0] cap_q, out_q;
         logic             rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_q <= '0;
               out_q <= '0;
               rd_q  <= 1'b0;
            end else begin
               if (accept) begin
                  rd_q  <= cmd_rd;
                  cap_q <= '0;
               end else if (sample) begin
                  cap_q <= {cap_q[VAL_W-2:0], miso};
               end
               if (finish) out_q <= rd_q ? cap_q : '0;
            end
         end
         assign rdata = out_q;
      end else begin : g_norx
         logic unused_rx;
         assign unused_rx = ^{clk, rst_n, accept, cmd_rd, sample, miso, finish};
         assign rdata = '0;
      end
   endgenerate
endmodule

// File: rtl/spi3w_reg_master.sv
module spi3w_reg_master
   import spi3w_pkg::*;
#(
   parameter int HALF_CYC  = 4,
   parameter int GUARD_CYC = 8,
   parameter bit HAS_MISO  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   output logic        cmd_ready,
   input  logic        cmd_rd,
   input  logic [7:0]  cmd_idx,
   input  logic [15:0] cmd_wdata,
   output logic        done,
   output logic [15:0] rdata,
   output logic        spi_cs_n,
   output logic        spi_sck,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   localparam int CNT_W = $clog2(GUARD_CYC + 1);

   initial begin
      if (HALF_CYC < 1)             $error("HALF_CYC must be at least 1");
      if (GUARD_CYC < 2 * HALF_CYC) $error("GUARD_CYC must be at least 2*HALF_CYC");
   end

   seq_state_t       state;
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;
   logic             accept, drive_first, shift, sample, park, load_second, finish;
   logic [FRAME_W-1:0] first_word, second_word;

   assign first_word  = {PFX_INDEX, 8'h00, cmd_idx};
   assign second_word = cmd_rd ? {PFX_READ, 16'h0000} : {PFX_WRITE, cmd_wdata};

   spi3w_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .expired(tmr_expired)
   );

   spi3w_seq #(.HALF_CYC(HALF_CYC), .GUARD_CYC(GUARD_CYC), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .tmr_expired(tmr_expired),
      .tmr_load(tmr_load), .tmr_val(tmr_val), .state(state), .accept(accept),
      .drive_first(drive_first), .shift(shift), .sample(sample), .park(park),
      .load_second(load_second), .finish(finish), .done(done)
   );

   spi3w_txshift u_tx (
      .clk(clk), .rst_n(rst_n), .load_first(accept), .first_word(first_word),
      .second_word(second_word), .load_second(load_second),
      .drive_first(drive_first), .shift(shift), .park(park), .mosi(spi_mosi)
   );

   spi3w_rxshift #(.HAS_MISO(HAS_MISO)) u_rx (
      .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_rd(cmd_rd),
      .sample(sample), .miso(spi_miso), .finish(finish), .rdata(rdata)
   );

   assign cmd_ready = (state == ST_IDLE);
   assign spi_sck   = (state != ST_LOW);
   assign spi_cs_n  = (state == ST_IDLE) || (state == ST_GAP);
endmodule

// File: rtl/spi3w_reg_master_chk.sv
module spi3w_reg_master_chk #(
   parameter int GUARD_CYC = 8
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic done,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic spi_mosi
);
   int gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      gap_cnt <= 0;
      else if (spi_cs_n && !cmd_ready) gap_cnt <= gap_cnt + 1;
      else                             gap_cnt <= 0;
   end

   AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (spi_cs_n && spi_sck && spi_mosi)); // R1
   AST_MOSI_HELD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && spi_sck && $past(spi_sck) && !$past(spi_cs_n)) |-> $stable(spi_mosi)); // R5
   AST_SCK_HIGH_AT_CS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(spi_cs_n) || $fell(spi_cs_n)) |-> (spi_sck && $past(spi_sck))); // R6
   AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      gap_cnt <= GUARD_CYC); // R7
   AST_ACCEPT_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_ready) |-> $past(cmd_valid)); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready); // R8
endmodule

bind spi3w_reg_master spi3w_reg_master_chk #(.GUARD_CYC(GUARD_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .done(done), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/spi3w_reg_master_test.sv
module spi3w_reg_master_test;
   localparam int HALF  = 4;
   localparam int GUARD = 8;
   localparam int NV    = 7;
   // {rd, idx, wdata, device reply}
   localparam logic [40:0] VEC [NV] = '{
      {1'b0, 8'hB7, 16'h030B, 16'h0000},
      {1'b1, 8'hB0, 16'h0000, 16'h2828},
      {1'b0, 8'h00, 16'h0000, 16'hFFFF},
      {1'b0, 8'hFF, 16'hFFFF, 16'h0000},
      {1'b1, 8'h5A, 16'h1234, 16'hA5C3},
      {1'b1, 8'hFF, 16'h0000, 16'hFFFF},
      {1'b1, 8'hA5, 16'hFFFF, 16'h0000}
   };

   logic clk = 0, rst_n = 0;
   logic cmd_valid = 0, cmd_rd = 0;
   logic [7:0] cmd_idx = 0;
   logic [15:0] cmd_wdata = 0;
   logic cmd_ready, done, spi_cs_n, spi_sck, spi_mosi, spi_miso;
   logic [15:0] rdata;
   logic wo_ready, wo_done, wo_cs, wo_sck, wo_mosi;
   logic [15:0] wo_rdata;

   int n_chk = 0, n_fail = 0;
   bit  finished = 0;

   always #10 clk = ~clk;

   spi3w_reg_master #(.HALF_CYC(HALF), .GUARD_CYC(GUARD), .HAS_MISO(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_rd(cmd_rd), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .done(done),
      .rdata(rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso));

   spi3w_reg_master #(.HALF_CYC(HALF), .GUARD_CYC(GUARD), .HAS_MISO(1'b0)) uut_wo (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(wo_ready),
      .cmd_rd(cmd_rd), .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .done(wo_done),
      .rdata(wo_rdata), .spi_cs_n(wo_cs), .spi_sck(wo_sck), .spi_mosi(wo_mosi),
      .spi_miso(1'b1));

   // device model
   logic [23:0] resp = 24'hFFFFFF, cap = 0;
   int k = 0, nfr = 0;
   logic [23:0] frames [8];
   int          fbits  [8];
   assign spi_miso = (k < 24) ? resp[23 - k] : 1'b1;

   always @(negedge spi_cs_n) if (rst_n) k = 0;
   always @(posedge spi_sck) if (rst_n && !spi_cs_n) begin
      cap = {cap[22:0], spi_mosi};
      k++;
   end
   always @(posedge spi_cs_n) if (rst_n && nfr < 8) begin
      frames[nfr] = cap;
      fbits[nfr]  = k;
      nfr++;
   end

   // bus timing monitor
   logic p_cs = 1, p_sck = 1, p_mosi = 1;
   int run = 0, tmg_err = 0, last_gap = 0;
   bit first_fall = 0;
   always @(negedge clk) if (rst_n) begin
      if (spi_cs_n == p_cs && spi_sck == p_sck) run++;
      else begin
         if (p_cs && !spi_cs_n) begin last_gap = run; first_fall = 1; end
         else if (!p_cs && spi_cs_n) begin if (run != HALF + GUARD) tmg_err++; end
         else if (!spi_cs_n && p_sck && !spi_sck) begin
            if (run != (first_fall ? GUARD : HALF)) tmg_err++;
            first_fall = 0;
         end
         else if (!spi_cs_n && !p_sck && spi_sck) begin if (run != HALF) tmg_err++; end
         run = 1;
      end
      if (!spi_cs_n && !p_cs && spi_sck && p_sck && spi_mosi != p_mosi) tmg_err++;
      p_cs = spi_cs_n; p_sck = spi_sck; p_mosi = spi_mosi;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_done(output logic [15:0] got, output logic [15:0] got_wo);
      int t = 0;
      while (!done && t < 5000) begin @(negedge clk); t++; end
      chk(done, "R8 done timeout", 32'(t), 32'd0);
      chk(cmd_ready, "R8 ready with done", {31'd0, cmd_ready}, 32'd1);
      got = rdata;
      got_wo = wo_rdata;
   endtask

   task automatic issue(input logic rd, input logic [7:0] idx, input logic [15:0] wd);
      @(negedge clk);
      cmd_valid = 1; cmd_rd = rd; cmd_idx = idx; cmd_wdata = wd;
      @(negedge clk);
      cmd_valid = 0;
      chk(!cmd_ready, "R8 busy after accept", {31'd0, cmd_ready}, 32'd0);
   endtask

   initial begin
      logic [15:0] got, got_wo;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready && !done, "R1 ready/done", {30'd0, cmd_ready, done}, 32'h2);
      chk(spi_cs_n && spi_sck && spi_mosi, "R1 idle lines",
          {29'd0, spi_cs_n, spi_sck, spi_mosi}, 32'h7);

      for (int v = 0; v < NV; v++) begin
         logic rd; logic [7:0] idx; logic [15:0] wd, rep;
         {rd, idx, wd, rep} = VEC[v];
         resp = {8'hC3, rep}; nfr = 0; tmg_err = 0;
         issue(rd, idx, wd);
         wait_done(got, got_wo);
         chk(nfr == 2, "R2 frame count", 32'(nfr), 32'd2);
         chk(fbits[0] == 24 && fbits[1] == 24, "R2 24 bits per frame",
             32'(fbits[0]), 32'd24);
         chk(frames[0] == {8'h70, 8'h00, idx}, "R2 index frame",
             {8'h0, frames[0]}, {8'h0, 8'h70, 8'h00, idx});
         if (rd) begin
            chk(frames[1] == 24'h730000, "R4 read frame", {8'h0, frames[1]}, 32'h730000);
            chk(got == rep, "R4 read data", {16'h0, got}, {16'h0, rep});
            chk(got_wo == 16'h0, "R10 write-only read data", {16'h0, got_wo}, 32'h0);
         end else begin
            chk(frames[1] == {8'h72, wd}, "R3 write frame",
                {8'h0, frames[1]}, {8'h0, 8'h72, wd});
            chk(got == 16'h0, "R9 write rdata zero", {16'h0, got}, 32'h0);
         end
         chk(tmg_err == 0, "R5 R6 phase/guard timing", 32'(tmg_err), 32'd0);
         chk(last_gap == GUARD, "R7 inter-frame gap", 32'(last_gap), 32'(GUARD));
         @(negedge clk);
         chk(!done, "R8 done single cycle", {31'd0, done}, 32'd0);
         chk(spi_cs_n && spi_sck && spi_mosi, "R1 idle after access",
             {29'd0, spi_cs_n, spi_sck, spi_mosi}, 32'h7);
      end

      // R8: cmd_valid held high during a busy access has no effect
      nfr = 0; resp = 24'hC3BEEF;
      @(negedge clk);
      cmd_valid = 1; cmd_rd = 0; cmd_idx = 8'h11; cmd_wdata = 16'h2222;
      @(negedge clk);
      cmd_rd = 1; cmd_idx = 8'hEE; cmd_wdata = 16'hDDDD;
      repeat (100) @(negedge clk);
      cmd_valid = 0;
      wait_done(got, got_wo);
      chk(frames[0] == 24'h700011, "R8 busy valid ignored idx", {8'h0, frames[0]}, 32'h700011);
      chk(frames[1] == 24'h722222, "R8 busy valid ignored data", {8'h0, frames[1]}, 32'h722222);
      repeat (40) @(negedge clk);
      chk(nfr == 2 && cmd_ready, "R8 no extra access", 32'(nfr), 32'd2);

      // R4: only the last 16 sampled bits kept (upper reply byte differs)
      nfr = 0; resp = 24'h00F00F;
      issue(1'b1, 8'h01, 16'h0);
      wait_done(got, got_wo);
      chk(got == 16'hF00F, "R4 last 16 bits", {16'h0, got}, 32'hF00F);

      // R8: back-to-back accesses
      nfr = 0;
      issue(1'b0, 8'h22, 16'h5555);
      wait_done(got, got_wo);
      issue(1'b0, 8'h33, 16'hAAAA);
      wait_done(got, got_wo);
      chk(nfr == 4 && frames[3] == 24'h72AAAA, "R3 back-to-back write",
          {8'h0, frames[3]}, 32'h72AAAA);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule